// File: doc/BRIEF.md
# Leading-One Segment Approximate Multiplier

This block multiplies two 8-bit operands approximately. It does not form the full 8x8 product. Each operand is cut down to a 4-bit window that starts at its most significant set bit, and only these two small windows are multiplied. The small product is then shifted back to the weight of the original operands, which gives a 16-bit estimate. Bits below each window are dropped and no rounding is applied.

The top bits of the two operands decide how the small product is formed. If both top bits match, it is an unsigned multiply. If they differ, it is a signed multiply: the window of the operand whose top bit is clear gets a zero bit added in front, so it stays non-negative. A caller presents both operands with a strobe. The estimate and a valid flag come out of a register one clock later.

Top module: `dsm_mult`

## Requirements
- R1: A synchronous active-high reset drives `prod` to 0 and `out_vld` to 0.
- R2: `out_vld` is high exactly in the cycle after a clock edge that samples `in_vld` high.
- R3: If either operand is zero, `prod` is 0.
- R4: An operand whose highest set bit is at position 3 or lower uses its low four bits as its window, with an offset of 0. For example, 3 x 5 gives 15 and 0x0F x 0x0F gives 0x00E1.
- R5: An operand whose highest set bit is at position p (4 to 7) uses bits p down to p-3 as its window, with an offset of p-3. Lower bits are discarded. The window product is shifted left by the sum of the two offsets. For example, 0x37 x 0x29 gives 0x0820.
- R6: If bit 7 of `a` equals bit 7 of `b`, the windows are multiplied as unsigned values. For example, 0xFF x 0xFF gives 0xE100. The result never exceeds the exact product.
- R7: If only `b` has bit 7 set, the window of `a` gets a zero bit added in front and the product is signed (two's complement in `prod`). For example, 0x05 x 0xF0 gives 0xFFB0, and 0x7F x 0x80 gives 0xC400.
- R8: The mirror of R7 applies when only `a` has bit 7 set. For example, 0x80 x 0x40 gives 0xE000.
- R9: A clock edge that samples `in_vld` low leaves `prod` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Operand strobe |
| a | input | 8 | First operand |
| b | input | 8 | Second operand |
| out_vld | output | 1 | Result valid, one cycle after the strobe |
| prod | output | 16 | Approximate product |

## Verification
The bench uses several input patterns, and each one separates a different part of the design:
- Zero operands confirm that the leading-one search returns a zero window and a zero offset.
- Small operands (leading one at bit 3 or lower) exercise the fixed low window.
- Mid-range values with bits below the window check truncation and the offset sum, since exact and approximate results differ there.
- The four top-bit combinations, including the extreme negative window and the largest positive window, tell unsigned treatment apart from the two mirrored signed treatments.

A final directed sequence shows that the result holds while the strobe is low, and that reset clears it.

// File: rtl/dsm_mult.sv
module dsm_mult #(
  parameter int W = 8,
  parameter int S = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_vld,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         out_vld,
  output logic [2*W-1:0] prod
);
  localparam int OW = $clog2(W);
  localparam int PW = 2 * W;

  function automatic logic [OW-1:0] win_off(input logic [W-1:0] v);
    logic [OW-1:0] o;
    o = '0;
    for (int i = S; i < W; i++)
      if (v[i]) o = OW'(i - S + 1);
    return o;
  endfunction

  logic [OW-1:0] off_a, off_b;
  logic [OW:0]   sh;
  logic [S-1:0]  sa, sb;
  logic [W-1:0]  a_sh, b_sh;
  logic [2*S-1:0] pu;
  logic signed [S:0] xa, xb;
  logic signed [2*S+1:0] ps;
  logic [PW-1:0] full;

  assign off_a = win_off(a);
  assign off_b = win_off(b);
  assign a_sh  = a >> off_a;
  assign b_sh  = b >> off_b;
  assign sa    = a_sh[S-1:0];
  assign sb    = b_sh[S-1:0];
  assign sh    = {1'b0, off_a} + {1'b0, off_b};
  assign pu    = sa * sb;

  always_comb begin
    case ({a[W-1], b[W-1]})
      2'b01: begin
        xa = $signed({1'b0, sa});
        xb = $signed({sb[S-1], sb});
      end
      2'b10: begin
        xa = $signed({sa[S-1], sa});
        xb = $signed({1'b0, sb});
      end
      default: begin
        xa = '0;
        xb = '0;
      end
    endcase
    ps = xa * xb;
    if (a[W-1] == b[W-1])
      full = {{(PW-2*S){1'b0}}, pu} << sh;
    else
      full = {{(PW-2*S-2){ps[2*S+1]}}, ps} << sh;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld <= 1'b0;
      prod    <= '0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) prod <= full;
    end
  end
endmodule

// File: rtl/dsm_mult_chk.sv
module dsm_mult_chk #(
  parameter int W = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           in_vld,
  input logic [W-1:0]   a,
  input logic [W-1:0]   b,
  input logic           out_vld,
  input logic [2*W-1:0] prod
);
  p_reset_r1: assert property (@(posedge clk) rst |=> (!out_vld && prod == '0));
  p_valid_r2: assert property (@(posedge clk) disable iff (rst) in_vld |=> out_vld);
  p_novalid_r2: assert property (@(posedge clk) disable iff (rst) !in_vld |=> !out_vld);
  p_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (in_vld && (a == '0 || b == '0)) |=> prod == '0);
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
    (in_vld && a[W-1] == b[W-1]) |=> prod <= ($past(a) * $past(b)));
  p_neg_r7: assert property (@(posedge clk) disable iff (rst)
    (in_vld && !a[W-1] && b[W-1] && a != '0) |=> prod[2*W-1]);
  p_neg_r8: assert property (@(posedge clk) disable iff (rst)
    (in_vld && a[W-1] && !b[W-1] && b != '0) |=> prod[2*W-1]);
  p_hold_r9: assert property (@(posedge clk) disable iff (rst) !in_vld |=> $stable(prod));
endmodule

bind dsm_mult dsm_mult_chk #(.W(W)) u_chk (.*);

// File: tb/dsm_mult_test.sv
module dsm_mult_test;
  localparam int PERIOD = 10;
  localparam int NV = 14;
  localparam logic [31:0] VEC [NV] = '{
    {8'h00, 8'h00, 16'h0000},
    {8'h00, 8'h55, 16'h0000},
    {8'h03, 8'h05, 16'h000F},
    {8'h0F, 8'h0F, 16'h00E1},
    {8'h08, 8'h07, 16'h0038},
    {8'h10, 8'h10, 16'h0100},
    {8'h37, 8'h29, 16'h0820},
    {8'hFF, 8'hFF, 16'hE100},
    {8'h80, 8'h90, 16'h4800},
    {8'h05, 8'hF0, 16'hFFB0},
    {8'h7F, 8'h80, 16'hC400},
    {8'h01, 8'h80, 16'hFF80},
    {8'h80, 8'h40, 16'hE000},
    {8'h00, 8'h80, 16'h0000}
  };
  localparam string TAG [NV] = '{"R3", "R3", "R4", "R4", "R4", "R5", "R5",
                                 "R6", "R6", "R7", "R7", "R7", "R8", "R3"};

  logic clk = 0, rst = 1, in_vld = 0;
  logic [7:0] a = 0, b = 0;
  logic out_vld;
  logic [15:0] prod;
  int checks = 0, fails = 0;
  bit done = 0;

  dsm_mult uut (.clk(clk), .rst(rst), .in_vld(in_vld), .a(a), .b(b),
                .out_vld(out_vld), .prod(prod));

  always #(PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [16:0] act, input logic [16:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    repeat (2) @(posedge clk);
    #1 check("R1", {out_vld, prod}, 17'h0);
    @(negedge clk) rst = 0;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      a = VEC[i][31:24]; b = VEC[i][23:16]; in_vld = 1;
      @(posedge clk); #1;
      check(TAG[i], {out_vld, prod}, {1'b1, VEC[i][15:0]});
    end
    // R9, R2: strobe low, new operands ignored
    @(negedge clk);
    a = 8'h33; b = 8'h22; in_vld = 0;
    @(posedge clk); #1;
    check("R2", {16'h0, out_vld}, 17'h0);
    check("R9", {1'b0, prod}, 17'h0000);
    @(negedge clk);
    a = 8'hFF; b = 8'hFF; in_vld = 1;
    @(posedge clk); #1;
    check("R6", {out_vld, prod}, {1'b1, 16'hE100});
    @(negedge clk) in_vld = 0;
    repeat (3) @(posedge clk);
    #1 check("R9", {out_vld, prod}, {1'b0, 16'hE100});
    // R1: reset mid-run
    @(negedge clk) rst = 1; in_vld = 1;
    @(posedge clk); #1;
    check("R1", {out_vld, prod}, 17'h0);
    @(negedge clk) rst = 0; in_vld = 0;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(PERIOD * 5000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule